// File: doc/BRIEF.md
# Burst-Format Register Configuration Loader

After reset this block reads a configuration image from an external serial memory one byte at a time and turns it into 32-bit register writes. It issues byte reads through an abstract port: it drives an address, raises a request and waits for a returning byte with a valid strobe. The serial bus protocol behind that port is modelled elsewhere. The image begins with a marker byte at offset 12 and a burst count at offset 13. A series of bursts follows. Each burst has a two-byte header, a word address and then a word count, followed by the data words, with the most significant byte of each word first.

Each assembled word goes out on a write port as a byte address, 32 bits of data and a one-cycle strobe. A write is only issued while both downstream management interfaces report that they are idle. Every read address is checked against an image size chosen by a 2-bit strap. If the image runs past that size, the loader stops and flags an overflow. When the loader finishes, on success or on error, it drops its busy flag, pulses a done strobe and, if enabled, holds an interrupt.

Top module: `cfg_burst_loader`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` is 1 and `rd_req`, `wr_stb`, `done` and `ovf_err` are 0. The first read request carries byte address 12.
- R2: If the byte at offset 12 is not A5h, the loader finishes after that single read and issues no register write.
- R3: The byte at offset 13 is the number of bursts. A value of zero finishes the load with no write.
- R4: In a burst header, the first byte is a word address and the second is a word count. The first write of the burst goes to byte address `word_address * 4`, that is, the word address with two zero bits appended.
- R5: Each 32-bit write word is built from four consecutive image bytes. The first byte forms bits [31:24] and the last byte forms bits [7:0].
- R6: The words of one burst go to consecutive word addresses, so each write's byte address is 4 above the previous one in that burst.
- R7: A header with a word count of zero causes no write, and the next header is read from the byte that follows it.
- R8: `wr_stb` is only high in cycles where both `fab_busy` and `mdio_busy` are low. A pending write waits for as long as either one is high, and it is never dropped.
- R9: `rd_req` stays high with a stable `rd_addr` until `rd_valid` is seen. Successive reads use addresses that rise by one, with no byte skipped or read twice.
- R10: `size_sel` = s sets the image size to 128·2^s bytes, so the highest address that may be read is 128·2^s − 1. A read that would go past that address is not issued. Instead `ovf_err` is set and stays set, and no further write follows. An image that ends exactly on the highest address completes without error.
- R11: When the loader finishes, `busy` falls and stays low, `done` is high for exactly one cycle, and no further read or write is issued until the next reset.
- R12: Once the loader has finished, `irq` equals `irq_en`. It stays 0 while the loader is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the load starts when it is released |
| size_sel | input | 2 | Image size strap: 128, 256, 512 or 1024 bytes |
| irq_en | input | 1 | Allows the interrupt output |
| rd_addr | output | 10 | Byte address of the pending memory read |
| rd_req | output | 1 | Memory read request, held until the byte returns |
| rd_data | input | 8 | Returned memory byte |
| rd_valid | input | 1 | One-cycle strobe that marks `rd_data` valid |
| fab_busy | input | 1 | Switch-fabric register interface busy |
| mdio_busy | input | 1 | PHY management interface busy |
| wr_addr | output | 12 | Register byte address of the write |
| wr_data | output | 32 | Register write data |
| wr_stb | output | 1 | One-cycle register write strobe |
| busy | output | 1 | High while the load is in progress |
| ovf_err | output | 1 | Sticky flag: the image ran past the strapped size |
| done | output | 1 | One-cycle pulse when the load ends |
| irq | output | 1 | Interrupt level after completion, gated by `irq_en` |

## Verification
A wrong parse position inside the sequencer does not stay hidden for long. At the next strobe it shows up as a write with the wrong address or data, or as a missing or extra write. It can also show up as a read count that differs from the model when `done` arrives. A fault in the pointer or bounds logic shows at the read port in the very cycle it happens: the request carries an unexpected address, or it is issued past the strapped size. The reference model predicts every read address and every write, so a divergence is caught on the clock where it first reaches a port. It is not left to be found at the end of the load.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [2:0] {
        S_MARK,
        S_NBURST,
        S_HADDR,
        S_HCOUNT,
        S_DATA,
        S_WRITE,
        S_FINISH,
        S_OVERFLOW
    } seq_state_t;

    // Highest readable byte address for a given size strap.
    function automatic int unsigned limit_of(input logic [SEL_W-1:0] sel,
                                             input int unsigned base_bytes);
        return (base_bytes << sel) - 1;
    endfunction

    // States that consume a byte from the memory.
    function automatic logic is_fetch(input seq_state_t s);
        return (s == S_MARK) || (s == S_NBURST) || (s == S_HADDR) ||
               (s == S_HCOUNT) || (s == S_DATA);
    endfunction

    function automatic logic is_terminal(input seq_state_t s);
        return (s == S_FINISH) || (s == S_OVERFLOW);
    endfunction

endpackage

// File: rtl/cbl_byte_reader.sv
module cbl_byte_reader
    import cbl_pkg::*;
#(
    parameter int BASE_BYTES = 128,
    parameter int RD_AW      = 10,
    parameter int START_OFS  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] size_sel,
    input  logic             want,
    output logic [RD_AW-1:0] rd_addr,
    output logic             rd_req,
    input  logic             rd_valid,
    output logic             byte_vld,
    output logic             ovf_hit
);
    localparam int PTR_W = RD_AW + 1;

    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] limit;
    logic             req_q;
    logic             past_lim;

    assign limit    = PTR_W'(limit_of(size_sel, BASE_BYTES));
    assign past_lim = ptr > limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= PTR_W'(START_OFS);
            req_q <= 1'b0;
        end else if (req_q && rd_valid) begin
            req_q <= 1'b0;
            ptr   <= ptr + 1'b1;
        end else if (!req_q && want && !past_lim) begin
            req_q <= 1'b1;
        end
    end

    assign rd_req   = req_q;
    assign rd_addr  = ptr[RD_AW-1:0];
    assign byte_vld = req_q && rd_valid;
    assign ovf_hit  = want && !req_q && past_lim;

endmodule

// File: rtl/cbl_word_packer.sv
module cbl_word_packer
    import cbl_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         shift_en,
    input  logic [BYTE_W-1:0]            byte_in,
    output logic [BYTE_W*WORD_BYTES-1:0] word,
    output logic                         word_last
);
    localparam int DATA_W = BYTE_W * WORD_BYTES;
    localparam int CW     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            word <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (shift_en) begin
            word <= {word[DATA_W-BYTE_W-1:0], byte_in};
            cnt  <= word_last ? '0 : cnt + 1'b1;
        end
    end

    assign word_last = shift_en && (cnt == CW'(WORD_BYTES - 1));

endmodule

// File: rtl/cbl_sequencer.sv
module cbl_sequencer
    import cbl_pkg::*;
#(
    parameter int                WA_W   = 10,
    parameter logic [BYTE_W-1:0] MARKER = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ovf_hit,
    input  logic              word_last,
    input  logic              fab_busy,
    input  logic              mdio_busy,
    output logic              want,
    output logic              pk_shift,
    output logic              pk_clear,
    output logic              wr_stb,
    output logic [WA_W-1:0]   waddr,
    output logic              busy,
    output logic              ovf_err,
    output logic              done
);
    seq_state_t        state;
    logic [BYTE_W-1:0] bursts_left;
    logic [BYTE_W-1:0] dw_left;
    logic              last_burst;

    assign last_burst = bursts_left == BYTE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_MARK;
            bursts_left <= '0;
            dw_left     <= '0;
            waddr       <= '0;
            ovf_err     <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ovf_hit) begin
                state   <= S_OVERFLOW;
                ovf_err <= 1'b1;
                done    <= 1'b1;
            end else begin
                unique case (state)
                    S_MARK: if (byte_vld) begin
                        if (byte_in == MARKER) begin
                            state <= S_NBURST;
                        end else begin
                            state <= S_FINISH;
                            done  <= 1'b1;
                        end
                    end
                    S_NBURST: if (byte_vld) begin
                        bursts_left <= byte_in;
                        if (byte_in == '0) begin
                            state <= S_FINISH;
                            done  <= 1'b1;
                        end else begin
                            state <= S_HADDR;
                        end
                    end
                    S_HADDR: if (byte_vld) begin
                        waddr <= WA_W'(byte_in);
                        state <= S_HCOUNT;
                    end
                    S_HCOUNT: if (byte_vld) begin
                        dw_left <= byte_in;
                        if (byte_in != '0) begin
                            state <= S_DATA;
                        end else if (last_burst) begin
                            state <= S_FINISH;
                            done  <= 1'b1;
                        end else begin
                            bursts_left <= bursts_left - 1'b1;
                            state       <= S_HADDR;
                        end
                    end
                    S_DATA: if (word_last) begin
                        state <= S_WRITE;
                    end
                    S_WRITE: if (wr_stb) begin
                        waddr   <= waddr + 1'b1;
                        dw_left <= dw_left - 1'b1;
                        if (dw_left != BYTE_W'(1)) begin
                            state <= S_DATA;
                        end else if (last_burst) begin
                            state <= S_FINISH;
                            done  <= 1'b1;
                        end else begin
                            bursts_left <= bursts_left - 1'b1;
                            state       <= S_HADDR;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign want     = is_fetch(state);
    assign pk_shift = (state == S_DATA) && byte_vld;
    assign pk_clear = (state == S_HCOUNT) && byte_vld;
    assign wr_stb   = (state == S_WRITE) && !fab_busy && !mdio_busy;
    assign busy     = !is_terminal(state);

endmodule

// File: rtl/cfg_burst_loader.sv
module cfg_burst_loader
    import cbl_pkg::*;
#(
    parameter int                BASE_BYTES = 128,
    parameter int                WORD_BYTES = 4,
    parameter int                HDR_W      = 8,
    parameter int                START_OFS  = 12,
    parameter logic [BYTE_W-1:0] MARKER     = 8'hA5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   size_sel,
    input  logic                         irq_en,
    output logic [9:0]                   rd_addr,
    output logic                         rd_req,
    input  logic [7:0]                   rd_data,
    input  logic                         rd_valid,
    input  logic                         fab_busy,
    input  logic                         mdio_busy,
    output logic [11:0]                  wr_addr,
    output logic [31:0]                  wr_data,
    output logic                         wr_stb,
    output logic                         busy,
    output logic                         ovf_err,
    output logic                         done,
    output logic                         irq
);
    localparam int MAX_BYTES = BASE_BYTES << ((1 << SEL_W) - 1);
    localparam int RD_AW     = $clog2(MAX_BYTES);
    localparam int WA_W      = HDR_W + 2;
    localparam int DATA_W    = BYTE_W * WORD_BYTES;

    logic              want;
    logic              byte_vld;
    logic              ovf_hit;
    logic              pk_shift;
    logic              pk_clear;
    logic              word_last;
    logic [WA_W-1:0]   waddr;
    logic [DATA_W-1:0] word;

    cbl_byte_reader #(
        .BASE_BYTES (BASE_BYTES),
        .RD_AW      (RD_AW),
        .START_OFS  (START_OFS)
    ) u_reader (
        .clk      (clk),
        .rst      (rst),
        .size_sel (size_sel),
        .want     (want),
        .rd_addr  (rd_addr),
        .rd_req   (rd_req),
        .rd_valid (rd_valid),
        .byte_vld (byte_vld),
        .ovf_hit  (ovf_hit)
    );

    cbl_word_packer #(
        .WORD_BYTES (WORD_BYTES)
    ) u_packer (
        .clk       (clk),
        .rst       (rst),
        .clear     (pk_clear),
        .shift_en  (pk_shift),
        .byte_in   (rd_data),
        .word      (word),
        .word_last (word_last)
    );

    cbl_sequencer #(
        .WA_W   (WA_W),
        .MARKER (MARKER)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_in   (rd_data),
        .ovf_hit   (ovf_hit),
        .word_last (word_last),
        .fab_busy  (fab_busy),
        .mdio_busy (mdio_busy),
        .want      (want),
        .pk_shift  (pk_shift),
        .pk_clear  (pk_clear),
        .wr_stb    (wr_stb),
        .waddr     (waddr),
        .busy      (busy),
        .ovf_err   (ovf_err),
        .done      (done)
    );

    assign wr_addr = {waddr, 2'b00};
    assign wr_data = word;
    assign irq     = irq_en && !busy;

endmodule

// File: rtl/cbl_checker.sv
module cbl_checker
    import cbl_pkg::*;
#(
    parameter int BASE_BYTES = 128,
    parameter int RD_AW      = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       size_sel,
    input logic [RD_AW-1:0] rd_addr,
    input logic             rd_req,
    input logic             rd_valid,
    input logic             wr_stb,
    input logic             busy,
    input logic             ovf_err,
    input logic             done
);
    logic [RD_AW:0] lim_w;
    assign lim_w = (RD_AW + 1)'(limit_of(size_sel, BASE_BYTES));

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R9
    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> ({1'b0, rd_addr} <= lim_w)); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R10
    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        ovf_err |-> !wr_stb); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_stb && !rd_req); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy); // R11

endmodule

bind cfg_burst_loader cbl_checker #(
    .BASE_BYTES (BASE_BYTES),
    .RD_AW      (RD_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .size_sel (size_sel),
    .rd_addr  (rd_addr),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .wr_stb   (wr_stb),
    .busy     (busy),
    .ovf_err  (ovf_err),
    .done     (done)
);

// File: tb/tb_cfg_burst_loader.sv
module tb_cfg_burst_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  size_sel = 2'd3;
    logic        irq_en = 1'b0;
    logic [9:0]  rd_addr;
    logic        rd_req;
    logic [7:0]  rd_data = 8'h00;
    logic        rd_valid = 1'b0;
    logic        fab_busy = 1'b0;
    logic        mdio_busy = 1'b0;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_stb;
    logic        busy;
    logic        ovf_err;
    logic        done;
    logic        irq;

    always #2 clk = ~clk;

    cfg_burst_loader dut (
        .clk(clk), .rst(rst), .size_sel(size_sel), .irq_en(irq_en),
        .rd_addr(rd_addr), .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .fab_busy(fab_busy), .mdio_busy(mdio_busy),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb),
        .busy(busy), .ovf_err(ovf_err), .done(done), .irq(irq)
    );

    logic [7:0]  mem [0:1023];
    int          nchk = 0;
    int          nfail = 0;
    int          lim;
    int          pp;
    int          exp_reads;
    bit          exp_ovf;
    int          exp_wa[$];
    logic [31:0] exp_wd[$];
    int          rd_cnt, wr_cnt, done_cnt, exp_rd, lat;
    bit          busy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: parse the image the way the requirements describe.
    function automatic int nxt();
        int v;
        if (pp > lim) return -1;
        v = int'(mem[pp]);
        pp++;
        return v;
    endfunction

    task automatic build_expect();
        int b, nb, a, c, x;
        logic [31:0] w;
        bit stop;
        exp_wa.delete();
        exp_wd.delete();
        pp = 12;
        exp_ovf = 1'b0;
        stop = 1'b0;
        b = nxt();
        if (b < 0) exp_ovf = 1'b1;
        else if (b == 8'hA5) begin
            nb = nxt();
            if (nb < 0) exp_ovf = 1'b1;
            else begin
                for (int i = 0; i < nb && !stop; i++) begin
                    a = nxt();
                    if (a < 0) begin exp_ovf = 1'b1; stop = 1'b1; end
                    else begin
                        c = nxt();
                        if (c < 0) begin exp_ovf = 1'b1; stop = 1'b1; end
                        for (int j = 0; j < c && !stop; j++) begin
                            w = '0;
                            for (int k = 0; k < 4 && !stop; k++) begin
                                x = nxt();
                                if (x < 0) begin exp_ovf = 1'b1; stop = 1'b1; end
                                else w = {w[23:0], x[7:0]};
                            end
                            if (!stop) begin
                                exp_wa.push_back((a + j) * 4);
                                exp_wd.push_back(w);
                            end
                        end
                    end
                end
            end
        end
        exp_reads = pp - 12;
    endtask

    // Memory responder, busy driver and per-clock comparison.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                rd_valid = 1'b0;
                lat = 0;
                exp_rd = 12;
            end else begin
                if (rd_valid) begin
                    rd_valid = 1'b0;
                end else if (rd_req) begin
                    chk(rd_addr == exp_rd[9:0], "R9", "read address", rd_addr, exp_rd);
                    if (lat == 0) begin
                        rd_data  = mem[rd_addr];
                        rd_valid = 1'b1;
                        exp_rd++;
                        rd_cnt++;
                        lat = int'(lfsr[1:0]) % 3;
                    end else begin
                        lat--;
                    end
                end
                if (done) done_cnt++;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                fab_busy  = busy_rand & lfsr[0];
                mdio_busy = busy_rand & lfsr[3] & lfsr[5];
                #1;
                if (wr_stb) begin
                    wr_cnt++;
                    chk(!fab_busy && !mdio_busy, "R8", "strobe while busy",
                        {fab_busy, mdio_busy}, 0);
                    if (exp_wa.size() == 0) begin
                        chk(1'b0, "R10", "unexpected write", wr_addr, 0);
                    end else begin
                        chk(wr_addr == exp_wa[0][11:0], "R6", "write address", wr_addr, exp_wa[0]);
                        chk(wr_data == exp_wd[0], "R5", "write data", wr_data, exp_wd[0]);
                        void'(exp_wa.pop_front());
                        void'(exp_wd.pop_front());
                    end
                end
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    endtask

    task automatic run_case(input string tag, input logic [1:0] sz,
                            input bit ien, input bit brand);
        int n_exp, t;
        lim = (128 << sz) - 1;
        build_expect();
        n_exp = exp_wa.size();
        @(negedge clk);
        rst = 1'b1;
        size_sel = sz;
        irq_en = ien;
        busy_rand = brand;
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(busy == 1'b1, "R1", "busy at reset", busy, 1);
        chk(!rd_req && !wr_stb && !done && !ovf_err, "R1", "quiet at reset",
            {rd_req, wr_stb, done, ovf_err}, 0);
        @(negedge clk);
        #1;
        chk(rd_req && rd_addr == 10'd12, "R1", "first read address", rd_addr, 12);
        chk(irq == 1'b0, "R12", "irq while busy", irq, 0);
        t = 0;
        while (busy && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, tag, "load timed out", t, 0);
        repeat (10) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R11", "busy after finish", busy, 0);
        chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
        chk(ovf_err == exp_ovf, "R10", "overflow flag", ovf_err, exp_ovf);
        chk(rd_cnt == exp_reads, "R9", "read count", rd_cnt, exp_reads);
        chk(wr_cnt == n_exp, tag, "write count", wr_cnt, n_exp);
        chk(exp_wa.size() == 0, "R4", "writes missing", exp_wa.size(), 0);
        chk(irq == ien, "R12", "irq after finish", irq, ien);
    endtask

    initial begin
        // R2: wrong marker
        clear_mem();
        mem[12] = 8'h5A;
        run_case("R2", 2'd3, 1'b1, 1'b0);

        // R3: zero bursts
        clear_mem();
        mem[12] = 8'hA5; mem[13] = 8'h00;
        run_case("R3", 2'd2, 1'b0, 1'b0);

        // R4, R5, R6: three bursts of 1, 2 and 3 words under busy traffic
        clear_mem();
        mem[12] = 8'hA5; mem[13] = 8'h03;
        mem[14] = 8'h11; mem[15] = 8'h01;
        mem[20] = 8'h22; mem[21] = 8'h02;
        mem[30] = 8'h33; mem[31] = 8'h03;
        run_case("R4", 2'd3, 1'b1, 1'b1);

        // R7: zero-count header, then a burst at the top word address
        clear_mem();
        mem[12] = 8'hA5; mem[13] = 8'h03;
        mem[14] = 8'h05; mem[15] = 8'h00;
        mem[16] = 8'h08; mem[17] = 8'h02;
        mem[26] = 8'hFF; mem[27] = 8'h01;
        run_case("R7", 2'd1, 1'b0, 1'b1);

        // R10: 128-byte image overruns mid-burst
        clear_mem();
        mem[12] = 8'hA5; mem[13] = 8'h01;
        mem[14] = 8'h02; mem[15] = 8'h40;
        run_case("R10", 2'd0, 1'b1, 1'b1);

        // R10: 256-byte image ending exactly on the last byte
        clear_mem();
        mem[12] = 8'hA5; mem[13] = 8'h01;
        mem[14] = 8'h00; mem[15] = 8'd60;
        run_case("R10", 2'd1, 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule